// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This watchdog is controlled by a single write port. Each write carries an enable bit and a key of `KEY_W` bits. After it is armed, the watchdog counts ticks of an external tick enable. If software does not service it within `STAGE1_TICKS` ticks, it raises an NMI request. If a further `STAGE2_TICKS` ticks pass with no service, it issues a one-cycle chip reset request and returns to the stopped state.

The key guards against stray writes. Once the watchdog runs, a write can restart or stop it only when its key is the bitwise complement of the stored key. Any other write only replaces the stored key and leaves the timing untouched. Software that services the watchdog therefore has to keep track of the key and invert it on every access.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_ni` is released the watchdog is stopped, and `nmi_o` and `rst_req_o` are both 0.
- R2: While stopped, a write with enable 0 has no effect: the watchdog stays stopped and raises no NMI, however many ticks follow.
- R3: While stopped, a write with enable 1 arms the watchdog, stores the written key and starts the first stage from a tick count of zero.
- R4: While running, a write with enable 0 whose key equals the bitwise NOT of the stored key stops the watchdog. `nmi_o` falls on the next cycle.
- R5: While running, a write with enable 1 whose key equals the bitwise NOT of the stored key restarts the first stage from zero, clears `nmi_o` and stores the written key.
- R6: While running, a write whose key is not the bitwise NOT of the stored key only replaces the stored key. The enable bit is ignored, and neither the stage nor the tick count changes.
- R7: `nmi_o` rises in the cycle after the `STAGE1_TICKS`-th tick since arming or restart. It stays high until a restart, a stop or the reset request.
- R8: In the cycle after the `STAGE2_TICKS`-th tick while `nmi_o` is high, `rst_req_o` pulses high for exactly one cycle. In that same cycle `nmi_o` is low and the watchdog is stopped.
- R9: A write in the same cycle as a tick takes effect before that tick. A valid restart in that cycle prevents the expiry the tick would otherwise cause.
- R10: Only cycles with `tick_i` high advance the timeout. Cycles without a tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Control write strobe |
| wr_en_i | input | 1 | Enable bit of the written word |
| wr_key_i | input | KEY_W | Key field of the written word |
| tick_i | input | 1 | Timebase tick enable |
| nmi_o | output | 1 | First-stage expiry, held as a level |
| rst_req_o | output | 1 | Second-stage expiry, one-cycle pulse |

## Verification
The bench targets several corner cases:
- A write with the wrong key arrives while the NMI is already high. A design that treated it as a service would drop the NMI, and a design that restarted the count would delay the reset.
- A restart coincides with the tick that would expire the stage. Here a wrong priority raises a spurious NMI.
- A write with enable 0 arrives while stopped. A design that stored its key or armed the watchdog would later raise an NMI that should never come.
- The reset pulse. A design that stretched it beyond one cycle, or left the NMI set, or kept counting afterwards, diverges from the cycle-accurate model.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic [1:0] {WD_IDLE, WD_ARMED, WD_ALERT} wd_state_e;
  typedef enum logic [2:0] {CMD_NONE, CMD_START, CMD_RESTART, CMD_STOP, CMD_REKEY} wd_cmd_e;
endpackage

// File: rtl/wdt_cmd_decode.sv
module wdt_cmd_decode
  import wdt_keyed_pkg::*;
#(
  parameter int KEY_W = 3
) (
  input  logic             wr_i,
  input  logic             en_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] stored_key_i,
  input  logic             started_i,
  output wd_cmd_e          cmd_o
);
  logic key_inv;
  assign key_inv = (key_i == ~stored_key_i);

  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i) begin
      if (!started_i)    cmd_o = en_i ? CMD_START : CMD_NONE;
      else if (!key_inv) cmd_o = CMD_REKEY;
      else               cmd_o = en_i ? CMD_RESTART : CMD_STOP;
    end
  end
endmodule

// File: rtl/wdt_stage_timer.sv
module wdt_stage_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && !clear_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || clear_i)  cnt_q <= '0;
    else if (expire_o)           cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R10: no tick, no progress
  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && !tick_i) |=> $stable(cnt_q));
  a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int KEY_W        = 3,
  parameter int STAGE1_TICKS = 1000,
  parameter int STAGE2_TICKS = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic             tick_i,
  output logic             nmi_o,
  output logic             rst_req_o
);
  localparam int MAX_T = (STAGE1_TICKS > STAGE2_TICKS) ? STAGE1_TICKS : STAGE2_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  wd_state_e        state_q, state_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             rst_req_q, rst_req_d;
  wd_cmd_e          cmd;
  logic             started, clear, expire;
  logic [CNT_W-1:0] limit;

  assign started = (state_q != WD_IDLE);
  assign clear   = (cmd == CMD_START) || (cmd == CMD_RESTART) || (cmd == CMD_STOP);
  assign limit   = (state_q == WD_ALERT) ? CNT_W'(STAGE2_TICKS) : CNT_W'(STAGE1_TICKS);

  wdt_cmd_decode #(.KEY_W(KEY_W)) i_dec (
    .wr_i        (wr_i),
    .en_i        (wr_en_i),
    .key_i       (wr_key_i),
    .stored_key_i(key_q),
    .started_i   (started),
    .cmd_o       (cmd)
  );

  wdt_stage_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (started),
    .clear_i (clear),
    .tick_i  (tick_i),
    .limit_i (limit),
    .expire_o(expire)
  );

  always_comb begin
    state_d   = state_q;
    key_d     = key_q;
    rst_req_d = 1'b0;
    unique case (cmd)
      CMD_START, CMD_RESTART: begin state_d = WD_ARMED; key_d = wr_key_i; end
      CMD_STOP:               begin state_d = WD_IDLE;  key_d = wr_key_i; end
      default: begin
        if (cmd == CMD_REKEY) key_d = wr_key_i;
        if (expire) begin
          if (state_q == WD_ARMED) state_d = WD_ALERT;
          else begin
            state_d   = WD_IDLE;
            rst_req_d = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= WD_IDLE;
      key_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      key_q     <= key_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign nmi_o     = (state_q == WD_ALERT);
  assign rst_req_o = rst_req_q;

  a_r8_rst_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r8_rst_after_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(nmi_o) && !nmi_o));
  a_r2_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!started && wr_i && !wr_en_i) |=> (state_q == WD_IDLE));
  a_r4_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && wr_i && !wr_en_i && (wr_key_i == ~key_q)) |=> (!nmi_o && !started));
  a_r6_rekey_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && wr_i && (wr_key_i != ~key_q) && !tick_i)
      |=> ((state_q == $past(state_q)) && (key_q == $past(wr_key_i))));
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
  localparam int KW = 3;
  localparam int S1 = 6;
  localparam int S2 = 3;

  logic clk = 0, rst_n = 0;
  logic wr = 0, wen = 0, tick = 0;
  logic [KW-1:0] wkey = '0;
  logic nmi, rreq;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  wdt_keyed #(.KEY_W(KW), .STAGE1_TICKS(S1), .STAGE2_TICKS(S2)) i_wdt_keyed (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_en_i(wen), .wr_key_i(wkey),
    .tick_i(tick), .nmi_o(nmi), .rst_req_o(rreq));

  // behavioural reference: 0 stopped, 1 running, 2 alert
  int m_st = 0, m_key = 0, m_cnt = 0;
  bit m_rst = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_key = 0; m_cnt = 0; m_rst = 0;
    end else begin
      bit inv;
      m_rst = 0;
      inv = wr && (int'(wkey) == ((~m_key) & 7));
      if (wr && m_st == 0) begin
        if (wen) begin m_st = 1; m_key = wkey; m_cnt = 0; end
      end else if (wr && inv) begin
        m_st = wen ? 1 : 0; m_key = wkey; m_cnt = 0;
      end else begin
        if (wr && m_st != 0) m_key = wkey;
        if (tick && m_st != 0) begin
          m_cnt++;
          if (m_st == 1 && m_cnt == S1) begin m_st = 2; m_cnt = 0; end
          else if (m_st == 2 && m_cnt == S2) begin m_st = 0; m_cnt = 0; m_rst = 1; end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_run++;
    if (nmi !== (m_st == 2)) begin
      n_fail++; $display("FAIL R7 model nmi: act=%0b exp=%0b", nmi, m_st == 2);
    end
    if (rreq !== m_rst) begin
      n_fail++; $display("FAIL R8 model rst_req: act=%0b exp=%0b", rreq, m_rst);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++; $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit e, input int k, input bit t);
    wr = w; wen = e; wkey = KW'(k); tick = t;
    @(posedge clk); @(negedge clk);
    wr = 0; wen = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; $display("FAIL watchdog timeout");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 nmi", nmi, 0); check("R1 rst_req", rreq, 0);

    step(1, 0, 5, 0); ticks(20);
    check("R2 ignored write", nmi, 0);

    step(1, 1, 2, 0); ticks(S1 - 1);
    check("R3 before expiry", nmi, 0);
    ticks(1);
    check("R7 nmi raised", nmi, 1);

    step(1, 1, 5, 0);
    check("R5 restart clears nmi", nmi, 0);
    ticks(S1 - 1);
    step(1, 1, 1, 0);
    check("R6 rekey no restart", nmi, 0);
    ticks(1);
    check("R6 count kept", nmi, 1);
    step(1, 0, 3, 0);
    check("R6 wrong key en0 no stop", nmi, 1);

    step(1, 0, 4, 0);
    check("R4 stop", nmi, 0);
    ticks(20);
    check("R4 stays stopped", nmi, 0);

    step(1, 1, 3, 0); ticks(S1);
    check("R7 alert", nmi, 1);
    ticks(S2 - 1);
    check("R8 no reset yet", rreq, 0);
    ticks(1);
    check("R8 reset pulse", rreq, 1); check("R8 nmi dropped", nmi, 0);
    step(0, 0, 0, 0);
    check("R8 pulse one cycle", rreq, 0);
    ticks(S1 + 2);
    check("R8 stopped after reset", nmi, 0);

    step(1, 1, 0, 0);
    repeat (40) step(0, 0, 0, 0);
    check("R10 no ticks no expiry", nmi, 0);
    ticks(S1 - 1);
    step(1, 1, 7, 1);
    check("R9 restart beats tick", nmi, 0);
    ticks(S1 - 1);
    check("R9 fresh count", nmi, 0);
    ticks(1);
    check("R9 expires after full stage", nmi, 1);

    step(1, 1, 6, 1);
    ticks(3);
    rst_n = 0; @(negedge clk);
    rst_n = 1; @(negedge clk);
    check("R1 after mid-run reset", nmi, 0);
    ticks(S1 + S2 + 2);
    check("R1 stopped after reset", rreq, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule